// File: doc/BRIEF.md
# Down-Counting Reload Timer

This block is a memory-mapped 32-bit down-counter with three word registers: a control word that software can read back, a load word that is write-only, and a count word that is read-only. The input clock goes through a power-of-two prescaler. Each prescaled tick moves the counter down by one. When a running counter sits at zero on a tick, the block emits a one-cycle interrupt pulse. It then either reloads from the load word and keeps going (periodic mode) or stops (one-shot mode).

To program it, software first writes the control word with only the clock enable set. It then writes the load word. Last, it writes the control word again with clock enable and start set, plus auto-reload if periodic operation is wanted. A load value of N gives N+1 ticks between interrupts. If the load word is all ones and auto-reload is set, the counter runs freely, and software inverts the count to get a rising timestamp. Several copies of the block can be placed at a 0x100-byte stride. The bus fabric decodes the select for each copy.

Top module: `reload_down_timer`

## Requirements
- R1: After reset, the control word and the count read as 0 and `irq` is low.
- R2: Register selection uses `word_addr`: 0 is control, 1 is load, 2 is count, 3 is unused. The control word reads back bits 5:0 as written, with all upper bits 0. The load word and the unused word read 0. Writes to the count word or the unused word change nothing.
- R3: The count word returns the current counter value. While running, the counter drops by exactly one on each prescaled tick that is not a load tick or a zero tick.
- R4: Control bit 0 is the clock enable. Control bits 4:2 hold the prescaler value p. While enabled, a tick occurs once every 2^(p+1) clock cycles, so p=0 divides by 2.
- R5: A write that changes control bit 5 (start) from 0 to 1 copies the load word into the counter on the next tick. Rewriting the control word with start already set causes no reload.
- R6: When the counter is running and is zero on a tick, `irq` is high for exactly one cycle. A load value N gives a period of N+1 ticks.
- R7: With control bit 1 (auto-reload) set, the zero tick reloads the load word and counting continues. With it clear, the zero tick clears the start bit and the count stays at 0.
- R8: Writing the control word with start clear stops counting from the next cycle. The count holds its value and no interrupt follows.
- R9: With the clock enable clear, no ticks occur and the count holds, even if start is set.
- R10: With the load word all ones and auto-reload set, the counter runs down from 0xFFFFFFFF, so its bitwise inverse rises by one per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Access select for this instance |
| wr | input | 1 | Write strobe, qualified by sel |
| word_addr | input | 2 | Word index within the register bank |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for word_addr (combinational) |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench targets the cycle on which an interrupt fires. A design that counts only N ticks, or that fires on the load tick, shows up as an `irq` pulse one tick early against the reference model. It also rewrites the control word while start is held, and writes a new load value during a run. A design that treats every start write as an edge would reload early and shift every later interrupt. It stops, freezes and restarts the counter with clock enable clear. A design with a leaky prescaler or a lost pending load would show the count drifting while frozen, or a wrong value after the restart. One-shot mode must clear its start bit; a design that left it set would read back 0x29 instead of 0x09 and keep counting or firing.

// File: rtl/reload_down_timer.sv
module reload_down_timer #(
  parameter int WIDTH   = 32,
  parameter int PS_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [1:0]       word_addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             irq
);
  localparam int PRE_W     = 1 << PS_BITS;
  localparam int START_BIT = PS_BITS + 2;
  localparam int CTRL_W    = PS_BITS + 3;
  localparam logic [PS_BITS-1:0] PS_MAX  = '1;
  localparam logic [PRE_W-1:0]   PRE_ALL = '1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [WIDTH-1:0]  load_q, cnt_q;
  logic [PRE_W-1:0]  pre_q, pre_mask;
  logic              pend_q, irq_q;

  wire               en  = ctrl_q[0];
  wire               arl = ctrl_q[1];
  wire [PS_BITS-1:0] ps  = ctrl_q[START_BIT-1:2];
  wire               run = ctrl_q[START_BIT];

  assign pre_mask = PRE_ALL >> (PS_MAX - ps);
  wire tick    = en && ((pre_q & pre_mask) == pre_mask);
  wire wr_ctrl = sel && wr && (word_addr == 2'd0);
  wire wr_load = sel && wr && (word_addr == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pre_q <= en ? pre_q + 1'b1 : '0;
      irq_q <= tick && run && !pend_q && (cnt_q == '0);
      if (tick && run) begin
        if (pend_q) begin
          cnt_q  <= load_q;
          pend_q <= 1'b0;
        end else if (cnt_q == '0) begin
          if (arl) cnt_q <= load_q;
          else     ctrl_q[START_BIT] <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) begin
        ctrl_q <= wdata[CTRL_W-1:0];
        if (!wdata[START_BIT]) pend_q <= 1'b0;
        else if (!run)         pend_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (word_addr)
      2'd0:    rdata = WIDTH'(ctrl_q);
      2'd2:    rdata = cnt_q;
      default: rdata = '0;
    endcase
  end

  assign irq = irq_q;
endmodule

// File: rtl/reload_down_timer_chk.sv
module reload_down_timer_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             tick,
  input logic             run,
  input logic             pend,
  input logic [WIDTH-1:0] cnt
);
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_from_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cnt) == '0));

  assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_hold_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !pend && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

bind reload_down_timer reload_down_timer_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .tick(tick),
  .run(run), .pend(pend_q), .cnt(cnt_q)
);

// File: tb/reload_down_timer_tb_top.sv
module reload_down_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  word_addr = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reload_down_timer dut_i (.clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr),
    .word_addr(word_addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  // reference model
  bit m_en, m_arl, m_start, m_pend, m_irq, m_tk, m_nirq;
  int m_ps, m_pre, m_div;
  logic [31:0] m_load, m_cnt;
  int irq_seen = 0, irq_model = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_arl = 0; m_start = 0; m_pend = 0; m_irq = 0;
      m_ps = 0; m_pre = 0; m_load = 0; m_cnt = 0;
    end else begin
      m_div  = 1 << (m_ps + 1);
      m_tk   = m_en && (m_pre % m_div == m_div - 1);
      m_nirq = m_tk && m_start && !m_pend && m_cnt == 0;
      m_pre  = m_en ? (m_pre + 1) % 256 : 0;
      if (m_tk && m_start) begin
        if (m_pend) begin m_cnt = m_load; m_pend = 0; end
        else if (m_cnt == 0) begin
          if (m_arl) m_cnt = m_load; else m_start = 0;
        end else m_cnt = m_cnt - 1;
      end
      if (sel && wr && word_addr == 2'd1) m_load = wdata;
      if (sel && wr && word_addr == 2'd0) begin
        if (!wdata[5]) m_pend = 0;
        else if (!m_start) m_pend = 1;
        m_en = wdata[0]; m_arl = wdata[1]; m_ps = int'(wdata[4:2]); m_start = wdata[5];
      end
      m_irq = m_nirq;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R6 irq actual %0b expected %0b at %0t", irq, m_irq, $time);
      end
      if (irq) irq_seen++;
      if (m_irq) irq_model++;
      if (word_addr == 2'd2) begin
        checks++;
        if (rdata !== m_cnt) begin
          errors++;
          $display("FAIL R3 count actual %h expected %h at %0t", rdata, m_cnt, $time);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] idx, input logic [31:0] d);
    @(posedge clk); #2;
    sel = 1; wr = 1; word_addr = idx; wdata = d;
    @(posedge clk); #2;
    sel = 0; wr = 0; word_addr = 2'd2;
  endtask

  task automatic rd_reg(input logic [1:0] idx, output logic [31:0] d);
    @(posedge clk); #2;
    word_addr = idx;
    #10 d = rdata;
    word_addr = 2'd2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int base;
    idle(3); #2 rst_n = 1;
    // R1 reset state
    rd_reg(2'd0, v); check("R1 ctrl", v, 32'h0);
    rd_reg(2'd2, v); check("R1 count", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 register map behaviour
    wr_reg(2'd0, 32'hFFFF_FF1D);
    rd_reg(2'd0, v); check("R2 ctrl readback", v, 32'h1D);
    wr_reg(2'd1, 32'h55);
    rd_reg(2'd1, v); check("R2 load reads zero", v, 32'h0);
    rd_reg(2'd3, v); check("R2 unused reads zero", v, 32'h0);
    wr_reg(2'd2, 32'h1234);
    wr_reg(2'd3, 32'h77);
    rd_reg(2'd2, v); check("R2 count write ignored", v, 32'h0);
    wr_reg(2'd0, 32'h0);

    // R4 R5 R6 R7 periodic, prescaler divide by 2
    wr_reg(2'd0, 32'h01);
    wr_reg(2'd1, 32'd5);
    base = irq_seen;
    wr_reg(2'd0, 32'h23);
    idle(60);
    check("R7 periodic irq count", irq_seen - base, 32'd4);
    check("R6 irq matches model", irq_seen, irq_model);

    // R5 rewrite with start held: no reload; new load used at next zero
    wr_reg(2'd1, 32'd9);
    wr_reg(2'd0, 32'h27);
    idle(80);
    check("R5 no reload on held start", irq_seen, irq_model);

    // R7 one-shot, prescaler p=2 (divide by 8)
    wr_reg(2'd0, 32'h09);
    wr_reg(2'd1, 32'd3);
    base = irq_seen;
    wr_reg(2'd0, 32'h29);
    idle(120);
    check("R7 one-shot single irq", irq_seen - base, 32'd1);
    rd_reg(2'd0, v); check("R7 start cleared", v, 32'h09);
    rd_reg(2'd2, v); check("R7 count stays zero", v, 32'h0);

    // R8 stop mid-count
    wr_reg(2'd0, 32'h01);
    wr_reg(2'd1, 32'd100);
    wr_reg(2'd0, 32'h23);
    idle(30);
    wr_reg(2'd0, 32'h03);
    rd_reg(2'd2, v);
    idle(20);
    rd_reg(2'd2, v2); check("R8 count holds after stop", v2, v);

    // R9 clock enable clear freezes, then restart with pending load
    wr_reg(2'd1, 32'd6);
    wr_reg(2'd0, 32'h22);
    idle(20);
    rd_reg(2'd2, v2); check("R9 frozen without enable", v2, v);
    wr_reg(2'd0, 32'h23);
    idle(3);
    rd_reg(2'd2, v2); check("R5 pending load applied", v2, m_cnt);

    // R4 slowest prescaler p=7 (divide by 256), one-shot load 1
    wr_reg(2'd0, 32'h1D);
    wr_reg(2'd1, 32'd1);
    base = irq_seen;
    wr_reg(2'd0, 32'h3D);
    idle(1000);
    check("R4 slow prescaler irq", irq_seen - base, 32'd1);

    // R10 free-running all-ones load
    wr_reg(2'd0, 32'h01);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    wr_reg(2'd0, 32'h23);
    idle(21);
    rd_reg(2'd2, v); check("R10 inverted count", ~v, 32'd10);
    check("R6 final irq agreement", irq_seen, irq_model);
    finish_run();
  end
endmodule